// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches six external interrupt request pins and turns each one into an interrupt request output. A 16-bit sense register packs a 2-bit mode field for every pin. Each field picks low-level sensing, falling-edge, rising-edge or both-edge detection. Every pin goes through a two-flop synchronizer before detection. An edge is found by comparing the synchronized value with its value one clock earlier.

In the edge modes, a detected edge moves the pin's small state machine from `PIN_IDLE` to `PIN_CAPTURED` (transition SET). It stays there (transition HOLD) until software writes 1 to the pin's bit in the status register (transition CLEAR). If a new edge and the clear arrive in the same cycle, the edge wins and the state stays `PIN_CAPTURED`. In level mode the request follows the synchronized pin while it is low, and the state machine is not used. Each request is gated by a per-pin enable bit.

Software reaches three registers through a simple synchronous bus: the sense register, the status register and the enable register. A reset clears all three. A standby input clears the sense register, so every pin returns to low-level sensing.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, reads of the sense, status and enable registers return 0, and `irq` is all zeros while every pin is high.
- R2: The sense register is at bus address 0. Pin n uses bits 2n+1:2n, and bits 11:0 read back as written. The field encodings are 00 low level, 01 falling edge, 10 rising edge and 11 both edges.
- R3: Bits 15:12 of the sense register always read as 0. Writing 1 to them has no effect.
- R4: In low-level mode (00), `irq[n]` is high while pin n is low and the pin is enabled. It drops when the pin returns high, and the mode never sets the pin's status bit.
- R5: In falling-edge mode (01), a high-to-low change on the pin sets status bit n and `irq[n]`. A low-to-high change sets nothing.
- R6: In rising-edge mode (10), a low-to-high change sets status bit n and `irq[n]`. A high-to-low change sets nothing.
- R7: In both-edge mode (11), either change of the pin sets status bit n and `irq[n]`.
- R8: The status register at address 1 holds pin n's captured flag in bit n. A captured flag stays set until a 1 is written to its bit. Writing 0 leaves it set.
- R9: If an edge is detected in the same cycle as a clear write to that bit, the flag stays set.
- R10: The enable register at address 2 holds one enable per pin in bits 5:0. With enable bit n at 0, `irq[n]` stays low, but status bit n still records edges.
- R11: A one-cycle pulse on `hw_standby` clears the sense register to 0.
- R12: A read issued in one cycle presents its data on `bus_rdata` after the next rising clock edge. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_standby | input | 1 | Clears the sense register |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 sense, 1 status, 2 enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_pin | input | 6 | External request pins, asynchronous |
| irq | output | 6 | Per-pin interrupt requests |

## Verification
The bench sweeps every pin through every one of the four modes. For each case it drives a high-to-low change and then a low-to-high change on that one pin, with the other pins held high in level mode. It checks the full `irq` vector and the status register after each change, which tells the four modes apart by which direction sets a flag and whether the output tracks the level. Separate patterns line up an edge with a clear write in the same cycle and set a flag while its enable is off. A further sequence writes 0 to a set status bit, and a standby pulse clears a fully written sense register.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    // 2-bit per-pin trigger selection; encoding is decoded by the pin logic
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_mode_e;

    // per-pin capture state
    typedef enum logic {
        PIN_IDLE     = 1'b0,
        PIN_CAPTURED = 1'b1
    } pin_st_e;

    // register select on the bus
    typedef enum logic [1:0] {
        REG_SENSE  = 2'd0,
        REG_STATUS = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam int FIELD_W = 2;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int WIDTH     = 6,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RESET_VAL}};
            stab_q <= {WIDTH{RESET_VAL}};
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int N_PINS = 6,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hw_standby,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [1:0]                  bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [N_PINS-1:0]           flags,
    output logic [N_PINS*FIELD_W-1:0]   sense_q,
    output logic [N_PINS-1:0]           enable_q,
    output logic [N_PINS-1:0]           clr_pulse
);

    localparam int USED_W = N_PINS * FIELD_W;

    reg_sel_e          sel;
    logic              wr_sense;
    logic              wr_status;
    logic              wr_enable;
    logic              rd_any;
    logic [DATA_W-1:0] rd_next;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_sense  = bus_sel && bus_wr && (sel == REG_SENSE);
    assign wr_status = bus_sel && bus_wr && (sel == REG_STATUS);
    assign wr_enable = bus_sel && bus_wr && (sel == REG_ENABLE);
    assign rd_any    = bus_sel && !bus_wr;

    // sense register: only the used field bits are stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else if (hw_standby) begin
            sense_q <= '0;
        end else if (wr_sense) begin
            sense_q <= bus_wdata[USED_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_enable) begin
            enable_q <= bus_wdata[N_PINS-1:0];
        end
    end

    // write-one-to-clear strobes for the per-pin capture logic
    always_comb begin
        clr_pulse = '0;
        if (wr_status) begin
            clr_pulse = bus_wdata[N_PINS-1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (sel)
            REG_SENSE:  rd_next[USED_W-1:0] = sense_q;
            REG_STATUS: rd_next[N_PINS-1:0] = flags;
            REG_ENABLE: rd_next[N_PINS-1:0] = enable_q;
            REG_SPARE:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            bus_rdata <= rd_next;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && sel == REG_SENSE) |=> (bus_rdata[DATA_W-1:USED_W] == '0)); // R3

    AST_STANDBY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> (sense_q == '0)); // R11

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && sel == REG_SPARE) |=> (bus_rdata == '0)); // R12

endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
    import irq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_sync,
    input  sense_mode_e mode,
    input  logic        enable,
    input  logic        clr,
    output logic        flag,
    output logic        irq
);

    logic    prev_q;
    logic    fell;
    logic    rose;
    logic    edge_hit;
    logic    raw_req;
    pin_st_e st_q;
    pin_st_e st_d;

    // one-clock history of the synchronized pin (idle level is high)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= pin_sync;
        end
    end

    assign fell = prev_q & ~pin_sync;
    assign rose = ~prev_q & pin_sync;

    always_comb begin
        unique case (mode)
            SNS_LOW:  edge_hit = 1'b0;
            SNS_FALL: edge_hit = fell;
            SNS_RISE: edge_hit = rose;
            SNS_BOTH: edge_hit = fell | rose;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: SET, HOLD, CLEAR (an edge beats a clear)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_IDLE: begin
                if (edge_hit) st_d = PIN_CAPTURED;
            end
            PIN_CAPTURED: begin
                if (clr && !edge_hit) st_d = PIN_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag = (st_q == PIN_CAPTURED);
        if (mode == SNS_LOW) begin
            raw_req = ~pin_sync;
        end else begin
            raw_req = flag;
        end
        irq = raw_req & enable;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (st_q == PIN_CAPTURED)); // R7

    AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && clr) |=> flag); // R9

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && !edge_hit) |=> !flag); // R8

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SNS_LOW && !flag) |=> !flag); // R4

endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_sense_pkg::*;
#(
    parameter int N_PINS = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_standby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_PINS-1:0] irq_pin,
    output logic [N_PINS-1:0] irq
);

    localparam int USED_W = N_PINS * FIELD_W;

    logic [N_PINS-1:0] pin_s;
    logic [N_PINS-1:0] flags;
    logic [N_PINS-1:0] enable_q;
    logic [N_PINS-1:0] clr_pulse;
    logic [USED_W-1:0] sense_q;

    irq_sync2 #(
        .WIDTH     (N_PINS),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin),
        .sync_out (pin_s)
    );

    irq_sense_regs #(
        .N_PINS (N_PINS),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_standby (hw_standby),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .flags      (flags),
        .sense_q    (sense_q),
        .enable_q   (enable_q),
        .clr_pulse  (clr_pulse)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        sense_mode_e mode_g;
        assign mode_g = sense_mode_e'(sense_q[g*FIELD_W +: FIELD_W]);

        irq_pin_sense u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_s[g]),
            .mode     (mode_g),
            .enable   (enable_q[g]),
            .clr      (clr_pulse[g]),
            .flag     (flags[g]),
            .irq      (irq[g])
        );

        AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !enable_q[g] |-> !irq[g]); // R10

        AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_g == SNS_LOW && enable_q[g]) |-> (irq[g] == !pin_s[g])); // R4
    end

endmodule

// File: tb/tb_irq_sense_ctrl.sv
module tb_irq_sense_ctrl;

    localparam int NP = 6;
    localparam int DW = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_standby = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] irq_pin = '1;
    logic [NP-1:0] irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_sense_ctrl #(.N_PINS(NP), .DATA_W(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_standby (hw_standby),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_pin    (irq_pin),
        .irq        (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] rd;
        logic [NP-1:0] bit_n;
        logic [DW-1:0] exp_irq;
        logic [DW-1:0] exp_st;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(2'd0, rd); check("R1 sense", rd, 16'h0000);
        bus_read(2'd1, rd); check("R1 status", rd, 16'h0000);
        bus_read(2'd2, rd); check("R1 enable", rd, 16'h0000);
        check("R1 irq", {10'd0, irq}, 16'h0000);

        // R2 field layout readback, R3 reserved bits
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                bus_write(2'd0, DW'(m) << (2 * p));
                bus_read(2'd0, rd);
                check("R2 sense readback", rd, DW'(m) << (2 * p));
            end
        end
        bus_write(2'd0, 16'hFFFF); bus_read(2'd0, rd); check("R3 reserved masked", rd, 16'h0FFF);
        bus_write(2'd0, 16'hF000); bus_read(2'd0, rd); check("R3 reserved only", rd, 16'h0000);
        bus_read(2'd3, rd); check("R12 spare address", rd, 16'h0000);

        // R4..R7 sweep: every pin, every mode, both directions
        bus_write(2'd2, 16'h003F);
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                bit_n = NP'(1) << p;
                irq_pin = '1;
                bus_write(2'd0, DW'(m) << (2 * p));
                settle();
                bus_write(2'd1, 16'h003F);
                // high to low
                irq_pin = ~bit_n;
                settle();
                exp_irq = (m == 0 || m == 1 || m == 3) ? DW'(bit_n) : '0;
                exp_st  = (m == 1 || m == 3) ? DW'(bit_n) : '0;
                check("R4-mode fall irq (R5 R7)", {10'd0, irq}, exp_irq);
                bus_read(2'd1, rd);
                check("R5 fall status (R4 R7)", rd, exp_st);
                bus_write(2'd1, 16'h003F);
                // low to high
                irq_pin = '1;
                settle();
                exp_irq = (m == 2 || m == 3) ? DW'(bit_n) : '0;
                check("R6 rise irq (R4 R7)", {10'd0, irq}, exp_irq);
                bus_read(2'd1, rd);
                check("R6 rise status (R7)", rd, exp_irq);
            end
        end

        // R8 writing 0 leaves flag, writing 1 clears
        bus_write(2'd1, 16'h0000);
        bus_read(2'd1, rd); check("R8 zero write keeps", rd, 16'h0020);
        bus_write(2'd1, 16'h0020);
        bus_read(2'd1, rd); check("R8 clear", rd, 16'h0000);

        // R9 edge coincides with clear
        bus_write(2'd0, 16'h0003);
        @(negedge clk); irq_pin[0] = 1'b0;
        settle();
        bus_read(2'd1, rd); check("R9 setup flag", rd, 16'h0001);
        @(negedge clk); irq_pin[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        bus_write(2'd1, 16'h0001);
        bus_read(2'd1, rd); check("R9 edge wins", rd, 16'h0001);
        bus_write(2'd1, 16'h0001);
        bus_read(2'd1, rd); check("R9 later clear", rd, 16'h0000);

        // R10 enable masking
        bus_write(2'd2, 16'h0000);
        bus_write(2'd0, 16'h0004);
        irq_pin[1] = 1'b0;
        settle();
        check("R10 masked irq", {10'd0, irq}, 16'h0000);
        bus_read(2'd1, rd); check("R10 status records", rd, 16'h0002);
        bus_write(2'd2, 16'h0002);
        @(negedge clk);
        check("R10 unmasked irq", {10'd0, irq}, 16'h0002);
        bus_read(2'd2, rd); check("R10 enable readback", rd, 16'h0002);
        irq_pin = '1;

        // R11 standby
        bus_write(2'd0, 16'h0FFF);
        @(negedge clk); hw_standby = 1'b1;
        @(negedge clk); hw_standby = 1'b0;
        bus_read(2'd0, rd); check("R11 standby clears", rd, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule